// File: doc/BRIEF.md
# Programmable Down-Counting Event Timer

This block is a single event timer that counts down on a shared microsecond tick enable rather than on every system clock. Software arms it with one 32-bit write that carries an enable flag, a repeat flag and a 29-bit count. When the count runs out, the timer raises a level interrupt. The interrupt stays high until software writes a clear bit into a second register.

The count follows an n+1 rule: a loaded value n expires on the (n+1)-th tick after the write, so a count of 0 fires on the very next tick and the longest delay is 2^29 ticks. In repeat mode the timer reloads itself on every expiry and fires every n+1 ticks until it is disabled. In single mode it clears its own enable flag when it expires. A write of zero stops it. Writing the arming register again while the timer runs restarts the countdown from the new value.

Register access is a write strobe and a read strobe with a byte offset. The arming register sits at offset 0x0 and the status/clear register at offset 0x4. Read data is registered and appears one cycle after the read strobe.

Top module: `event_timer`

## Requirements
- R1: After reset `irq` is 0, and reads of offset 0x0 and offset 0x4 both return 0.
- R2: A write to offset 0x0 stores the enable flag from bit 31, the repeat flag from bit 30 and the count from bits 28:0. A read of offset 0x0 returns these fields in the same positions, with bit 29 read as 0 whatever was written there.
- R3: With the enable flag set and count n, `irq` stays 0 through the first n ticks after the write and is 1 in the cycle after the (n+1)-th tick, so a count of 0 fires on the first tick.
- R4: The remaining count, read at offset 0x4 bits 28:0, decreases by one on each cycle with `tick_en` high and does not change on cycles with `tick_en` low.
- R5: In single mode (bit 30 clear), expiry clears the enable flag, so a read of offset 0x0 shows bit 31 as 0, and later ticks raise no further interrupt.
- R6: In repeat mode (bit 30 set), the remaining count reloads on expiry, the enable flag stays set, and the timer fires again every n+1 ticks.
- R7: Writing 0 to offset 0x0 stops the timer; no tick raises `irq` afterwards.
- R8: `irq` stays 1 until a write to offset 0x4 with bit 30 set. A write to offset 0x4 with bit 30 clear has no effect. A read of offset 0x4 shows the pending flag in bit 30.
- R9: If an expiry and a clear write fall in the same cycle, the expiry wins and `irq` stays 1.
- R10: A write to offset 0x0 while the timer runs restarts the countdown from the new count. A tick in the same cycle as that write is not counted.
- R11: The full 29-bit count 0x1FFFFFFF is accepted and reads back intact as the remaining count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Shared microsecond count enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after rd_en |
| irq | output | 1 | Level interrupt, high while an expiry is pending |

## Verification
Every register in the block updates at the clock edge that samples its strobe or tick. The effect of a write or tick therefore shows on `irq` one cycle later, and read data appears one cycle after `rd_en`. The bench drives each stimulus for one cycle from the falling edge and samples at the next falling edge, which comes after exactly one rising edge. Expiry checks count ticks in the bench and compare `irq` just before and just after the (n+1)-th tick. This pins down the n+1 rule with no slack of a cycle either way.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;

  localparam int DATA_W   = 32;
  localparam int CNT_W    = 29;
  localparam int ADDR_W   = 4;
  localparam int EN_BIT   = 31;
  localparam int REP_BIT  = 30;
  localparam int CLR_BIT  = 30;
  localparam int PEND_BIT = 30;
  localparam logic [ADDR_W-1:0] ARM_OFS  = 4'h0;
  localparam logic [ADDR_W-1:0] STAT_OFS = 4'h4;

  typedef struct packed {
    logic             en;
    logic             rep;
    logic [CNT_W-1:0] cnt;
  } arm_t;

  // Remaining count after one counted tick that is not an expiry.
  function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] cur);
    return cur - {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  // The n+1 rule: the tick that finds the count at zero is the expiry.
  function automatic logic at_terminal(input logic [CNT_W-1:0] cur);
    return cur == '0;
  endfunction

  function automatic logic [DATA_W-1:0] pack_arm(input arm_t a);
    logic [DATA_W-1:0] w;
    w = '0;
    w[EN_BIT]    = a.en;
    w[REP_BIT]   = a.rep;
    w[CNT_W-1:0] = a.cnt;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] pack_stat(input logic pend,
                                                  input logic [CNT_W-1:0] rem);
    logic [DATA_W-1:0] w;
    w = '0;
    w[PEND_BIT]  = pend;
    w[CNT_W-1:0] = rem;
    return w;
  endfunction

endpackage

// File: rtl/tmr_wdec.sv
module tmr_wdec
  import evt_tmr_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              arm_wr,
  output logic              clr_wr,
  output arm_t              arm_val
);

  always_comb begin
    arm_wr      = wr_en && (addr == ARM_OFS);
    clr_wr      = wr_en && (addr == STAT_OFS) && wdata[CLR_BIT];
    arm_val.en  = wdata[EN_BIT];
    arm_val.rep = wdata[REP_BIT];
    arm_val.cnt = wdata[CNT_W-1:0];
  end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import evt_tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             arm_wr,
  input  arm_t             arm_val,
  output arm_t             arm_q,
  output logic [CNT_W-1:0] remain,
  output logic             expire
);

  logic counted;

  assign counted = tick && arm_q.en && !arm_wr;
  assign expire  = counted && at_terminal(remain);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q  <= '0;
      remain <= '0;
    end else if (arm_wr) begin
      arm_q  <= arm_val;
      remain <= arm_val.cnt;
    end else if (expire) begin
      if (arm_q.rep) remain <= arm_q.cnt;
      else           arm_q.en <= 1'b0;
    end else if (counted) begin
      remain <= count_step(remain);
    end
  end

endmodule

// File: rtl/tmr_pend.sv
module tmr_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr_wr,
  output logic pend
);

  always_ff @(posedge clk) begin
    if (!rst_n)      pend <= 1'b0;
    else if (expire) pend <= 1'b1;
    else if (clr_wr) pend <= 1'b0;
  end

endmodule

// File: rtl/event_timer.sv
module event_timer
  import evt_tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  logic             arm_wr;
  logic             clr_wr;
  arm_t             arm_val;
  arm_t             arm_q;
  logic [CNT_W-1:0] remain;
  logic             expire;
  logic             pend;

  tmr_wdec u_wdec (
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .arm_wr  (arm_wr),
    .clr_wr  (clr_wr),
    .arm_val (arm_val)
  );

  tmr_core u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_en),
    .arm_wr  (arm_wr),
    .arm_val (arm_val),
    .arm_q   (arm_q),
    .remain  (remain),
    .expire  (expire)
  );

  tmr_pend u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .expire (expire),
    .clr_wr (clr_wr),
    .pend   (pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      if (addr == ARM_OFS)       rdata <= pack_arm(arm_q);
      else if (addr == STAT_OFS) rdata <= pack_stat(pend, remain);
      else                       rdata <= '0;
    end
  end

  assign irq = pend;

endmodule

// File: rtl/event_timer_chk.sv
module event_timer_chk
  import evt_tmr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             arm_wr,
  input logic             clr_wr,
  input logic             expire,
  input arm_t             arm_q,
  input logic [CNT_W-1:0] remain,
  input logic             irq
);

  p_expire_sets_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq);

  p_clear_drops_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !expire) |=> !irq);

  p_irq_only_on_expiry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !expire) |=> !irq);

  p_expiry_beats_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && clr_wr) |=> irq);

  p_single_disables_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !arm_q.rep) |=> !arm_q.en);

  p_repeat_reloads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && arm_q.rep) |=> (arm_q.en && remain == $past(arm_q.cnt)));

  p_step_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && arm_q.en && !arm_wr && remain != '0) |=> remain == $past(remain) - 1'b1);

  p_hold_without_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !arm_wr) |=> ($stable(remain) && $stable(arm_q.en)));

  p_disabled_never_fires_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_q.en |-> !expire);

endmodule

bind event_timer event_timer_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick   (tick_en),
  .arm_wr (arm_wr),
  .clr_wr (clr_wr),
  .expire (expire),
  .arm_q  (arm_q),
  .remain (remain),
  .irq    (irq)
);

// File: tb/event_timer_bench.sv
module event_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  localparam int unsigned VEC_N[NVEC] = '{0, 1, 3, 7, 2, 12};
  localparam bit          VEC_R[NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;

  event_timer u_event_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle of stimulus, set at a falling edge and removed at the next.
  task automatic step(input logic w, input logic [3:0] a, input logic [31:0] d,
                      input logic t, input logic r);
    wr_en = w; addr = a; wdata = d; tick_en = t; rd_en = r;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0; rd_en = 1'b0; wdata = '0;
  endtask

  task automatic arm(input logic [31:0] d);
    step(1'b1, 4'h0, d, 1'b0, 1'b0);
  endtask

  task automatic clear_irq();
    step(1'b1, 4'h4, 32'h4000_0000, 1'b0, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'h0, '0, 1'b1, 1'b0);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    step(1'b0, a, '0, 1'b0, 1'b1);
    v = rdata;
  endtask

  function automatic logic [31:0] arm_word(input bit en, input bit rep, input int unsigned n);
    return {en, rep, 1'b0, n[28:0]};
  endfunction

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(4'h0, v); chk("R1 arm reg", v, 32'h0);
    rd(4'h4, v); chk("R1 status reg", v, 32'h0);

    // R3 table walk over counts and modes
    for (int k = 0; k < NVEC; k++) begin
      arm(arm_word(1'b1, VEC_R[k], VEC_N[k]));
      ticks(VEC_N[k]);
      chk("R3 no early fire", {31'b0, irq}, 32'h0);
      ticks(1);
      chk("R3 fire at n+1", {31'b0, irq}, 32'h1);
      rd(4'h0, v);
      chk("R5/R6 enable after expiry", {31'b0, v[31]}, {31'b0, VEC_R[k]});
      rd(4'h4, v);
      chk("R8 pending bit", {31'b0, v[30]}, 32'h1);
      chk("R6 remain after expiry", {3'b0, v[28:0]}, VEC_R[k] ? VEC_N[k] : 32'h0);
      clear_irq();
      chk("R8 cleared", {31'b0, irq}, 32'h0);
    end

    // R2 field readback, bit 29 ignored
    arm(32'h7000_0015);
    rd(4'h0, v); chk("R2 fields", v, 32'h5000_0015);

    // R5 single mode no refire after clear
    arm(arm_word(1'b1, 1'b0, 2));
    ticks(3); clear_irq(); ticks(5);
    chk("R5 no refire", {31'b0, irq}, 32'h0);

    // R4 count steps only on ticks
    arm(arm_word(1'b1, 1'b0, 10));
    ticks(3);
    rd(4'h4, v); chk("R4 remain after 3 ticks", {3'b0, v[28:0]}, 32'd7);
    repeat (4) step(1'b0, 4'h0, '0, 1'b0, 1'b0);
    rd(4'h4, v); chk("R4 hold without ticks", {3'b0, v[28:0]}, 32'd7);

    // R10 restart mid-run
    arm(arm_word(1'b1, 1'b0, 2));
    ticks(2); chk("R10 restart no early", {31'b0, irq}, 32'h0);
    ticks(1); chk("R10 restart fires", {31'b0, irq}, 32'h1);
    clear_irq();

    // R10 tick coincident with write is not counted
    step(1'b1, 4'h0, arm_word(1'b1, 1'b0, 3), 1'b1, 1'b0);
    ticks(3); chk("R10 coincident tick ignored", {31'b0, irq}, 32'h0);
    ticks(1); chk("R10 fires after full count", {31'b0, irq}, 32'h1);
    clear_irq();

    // R6 repeat mode, two periods
    arm(arm_word(1'b1, 1'b1, 4));
    ticks(5); chk("R6 first period", {31'b0, irq}, 32'h1);
    clear_irq();
    ticks(4); chk("R6 second period early", {31'b0, irq}, 32'h0);
    ticks(1); chk("R6 second period", {31'b0, irq}, 32'h1);
    clear_irq();

    // R7 write zero stops
    arm(32'h0);
    ticks(8);
    chk("R7 stopped", {31'b0, irq}, 32'h0);
    rd(4'h0, v); chk("R7 arm reg zero", v, 32'h0);

    // R8 clear write with bit 30 low has no effect; R9 expiry beats clear
    arm(arm_word(1'b1, 1'b1, 0));
    ticks(1); chk("R9 setup fire", {31'b0, irq}, 32'h1);
    step(1'b1, 4'h4, 32'hBFFF_FFFF, 1'b0, 1'b0);
    chk("R8 bit30 low no effect", {31'b0, irq}, 32'h1);
    step(1'b1, 4'h4, 32'h4000_0000, 1'b1, 1'b0);
    chk("R9 expiry wins over clear", {31'b0, irq}, 32'h1);
    clear_irq();
    chk("R9 later clear works", {31'b0, irq}, 32'h0);
    arm(32'h0);

    // R11 full width count
    arm(32'h9FFF_FFFF);
    rd(4'h4, v); chk("R11 max count", {3'b0, v[28:0]}, 32'h1FFF_FFFF);
    ticks(1);
    rd(4'h4, v); chk("R11 max count step", {3'b0, v[28:0]}, 32'h1FFF_FFFE);
    arm(32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule